// File: doc/BRIEF.md
# Filtered Phase-Lock Indicator

This block turns the raw up and down error pulses of a phase/frequency detector into a clean lock flag. It runs on a fast sampling clock and treats the span between two comparison strobes as one comparison window. Within each window it counts the sample ticks during which either error pulse is high. That count is the phase error of the window. The block evaluates that width exactly once per window.

Each evaluated width falls into one of three classes, set by two parameters. A tight width extends a run of good windows, and a full run raises the lock flag. A wide width drops the flag at once. A width between the two limits only restarts the run. The lock flag therefore rises slowly and falls fast. A power-down input forces the flag high while it is asserted. After power-down the flag starts again from unlocked, with an empty run.

Both limits and the run length are counted in sample ticks and windows, so the block can be retimed for another sampling clock. By default the limits are 6 ticks and 12 ticks, which is 15 ns and 30 ns at a 400 MHz sampling clock. A parameter selects how many synchronizer stages the error and strobe inputs pass through.

Top module: `lock_filter`

## Requirements
- R1: After reset `lock_out` is low. No width is evaluated before the first `cmp_strobe` has opened a window.
- R2: The width of a window is the number of sample ticks in which `err_up` or `err_dn` (or both) is high. It is evaluated when that pulse falls, or at the next `cmp_strobe` if no pulse fell in the window. There is at most one evaluation per window.
- R3: A width below TIGHT_TICKS (default 6) is good. After GOOD_RUN (default 5) good windows in a row, `lock_out` goes high. The run counter never exceeds GOOD_RUN.
- R4: A width above LOOSE_TICKS (default 12) clears the run and drops `lock_out` after that single window.
- R5: A width from TIGHT_TICKS to LOOSE_TICKS inclusive clears the run and leaves the lock state as it was.
- R6: A window with no error pulse has width 0 and counts as good.
- R7: A pulse whose falling edge arrives in the same tick as the next `cmp_strobe` is evaluated once, with its full width, for the window it started in.
- R8: While `pwr_down` is high, `lock_out` is high from the next clock edge on. The run and the width measurement are cleared.
- R9: When `pwr_down` is released, the internal lock state is low and the run is empty. `lock_out` stays low until GOOD_RUN good windows have been evaluated after the first new strobe.
- R10: The width counter saturates at 2**CNT_W-1 and does not wrap. A pulse longer than that still counts as wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_smp | input | 1 | Sampling clock; the width is measured in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_strobe | input | 1 | One-tick pulse marking each reference edge, which opens a new window |
| err_up | input | 1 | Pump-up error pulse from the phase detector |
| err_dn | input | 1 | Pump-down error pulse from the phase detector |
| pwr_down | input | 1 | Power-down; forces the lock output high |
| lock_out | output | 1 | Registered filtered lock indication |

## Verification
Two events can land in the same sample tick: the end of an error pulse and the comparison strobe that opens the next window. The bench provokes this by ending a pulse exactly on the strobe tick, with both a tight width and a wide width.

It judges the result through the lock output and the run length. If the window were evaluated twice, lock would come too early. If the evaluation were lost, lock would come too late, or a wide pulse would fail to drop it. Random windows that mix widths, pulse sources and power-down stretches are compared against a window-level model in the bench.

// File: rtl/lkf_pkg.sv
package lkf_pkg;

   typedef enum logic [1:0] {
      CLS_GOOD = 2'd0,
      CLS_MID  = 2'd1,
      CLS_BAD  = 2'd2
   } width_cls_e;

   // Map a measured width onto the three hysteresis classes.
   function automatic width_cls_e classify(input int width, input int tight, input int loose);
      if (width < tight)
         return CLS_GOOD;
      else if (width > loose)
         return CLS_BAD;
      else
         return CLS_MID;
   endfunction

endpackage

// File: rtl/lkf_sync.sv
module lkf_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= din;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign dout = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lkf_width_meter.sv
module lkf_width_meter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             err,
   input  logic             strobe,
   output logic             eval_v,
   output logic [CNT_W-1:0] eval_w
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             err_p;
   logic [CNT_W-1:0] cnt;
   logic             done;
   logic             armed;
   logic             fall;
   logic             fire;
   logic [CNT_W-1:0] cnt_inc;

   // falling edge of the combined error pulse
   assign fall    = err_p & ~err;
   // one evaluation per window: first fall, else the closing strobe
   assign fire    = armed & ~done & (fall | strobe);
   assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_p  <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
         armed  <= 1'b0;
         eval_v <= 1'b0;
         eval_w <= '0;
      end else if (clear) begin
         err_p  <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
         armed  <= 1'b0;
         eval_v <= 1'b0;
         eval_w <= '0;
      end else begin
         err_p  <= err;
         eval_v <= fire;
         if (fire) eval_w <= cnt;
         if (strobe) begin
            cnt   <= err ? CNT_ONE : '0;
            done  <= 1'b0;
            armed <= 1'b1;
         end else begin
            if (err) cnt <= cnt_inc;
            if (fall && armed) done <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/lkf_run_filter.sv
module lkf_run_filter
   import lkf_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int TIGHT_TICKS = 6,
   parameter int LOOSE_TICKS = 12,
   parameter int GOOD_RUN    = 5,
   localparam int RUN_W      = $clog2(GOOD_RUN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_down,
   input  logic             eval_v,
   input  logic [CNT_W-1:0] eval_w,
   output logic [RUN_W-1:0] run_cnt,
   output logic             locked,
   output logic             lock_out
);

   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GOOD_RUN);
   localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

   width_cls_e       cls;
   logic [RUN_W-1:0] run_n;
   logic             locked_n;

   assign cls = classify(int'(eval_w), TIGHT_TICKS, LOOSE_TICKS);

   always_comb begin
      run_n    = run_cnt;
      locked_n = locked;
      if (eval_v) begin
         case (cls)
            CLS_GOOD: begin
               if (run_cnt != RUN_MAX) run_n = run_cnt + RUN_ONE;
               if (run_n == RUN_MAX) locked_n = 1'b1;
            end
            CLS_MID: run_n = '0;
            CLS_BAD: begin
               run_n    = '0;
               locked_n = 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt  <= '0;
         locked   <= 1'b0;
         lock_out <= 1'b0;
      end else if (pwr_down) begin
         run_cnt  <= '0;
         locked   <= 1'b0;
         lock_out <= 1'b1;
      end else begin
         run_cnt  <= run_n;
         locked   <= locked_n;
         lock_out <= locked_n;
      end
   end

endmodule

// File: rtl/lock_filter.sv
module lock_filter #(
   parameter int CNT_W       = 8,
   parameter int TIGHT_TICKS = 6,
   parameter int LOOSE_TICKS = 12,
   parameter int GOOD_RUN    = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_smp,
   input  logic rst_n,
   input  logic cmp_strobe,
   input  logic err_up,
   input  logic err_dn,
   input  logic pwr_down,
   output logic lock_out
);

   localparam int RUN_W = $clog2(GOOD_RUN + 1);

   // elaboration-time parameter checks
   generate
      if (TIGHT_TICKS < 1) begin : g_bad_tight
         $error("lock_filter: TIGHT_TICKS must be at least 1");
      end
      if (LOOSE_TICKS < TIGHT_TICKS) begin : g_bad_order
         $error("lock_filter: LOOSE_TICKS must not be below TIGHT_TICKS");
      end
      if (LOOSE_TICKS >= (1 << CNT_W) - 1) begin : g_bad_cnt
         $error("lock_filter: CNT_W too narrow for LOOSE_TICKS");
      end
      if (GOOD_RUN < 1) begin : g_bad_run
         $error("lock_filter: GOOD_RUN must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("lock_filter: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [2:0]       in_raw;
   logic [2:0]       in_s;
   logic             err_any;
   logic             eval_v;
   logic [CNT_W-1:0] eval_w;
   logic [RUN_W-1:0] run_cnt;
   logic             locked;

   assign in_raw  = {cmp_strobe, err_dn, err_up};
   assign err_any = in_s[0] | in_s[1];

   lkf_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk_smp),
      .rst_n (rst_n),
      .din   (in_raw),
      .dout  (in_s)
   );

   lkf_width_meter #(.CNT_W(CNT_W)) u_meter (
      .clk    (clk_smp),
      .rst_n  (rst_n),
      .clear  (pwr_down),
      .err    (err_any),
      .strobe (in_s[2]),
      .eval_v (eval_v),
      .eval_w (eval_w)
   );

   lkf_run_filter #(
      .CNT_W       (CNT_W),
      .TIGHT_TICKS (TIGHT_TICKS),
      .LOOSE_TICKS (LOOSE_TICKS),
      .GOOD_RUN    (GOOD_RUN)
   ) u_filter (
      .clk      (clk_smp),
      .rst_n    (rst_n),
      .pwr_down (pwr_down),
      .eval_v   (eval_v),
      .eval_w   (eval_w),
      .run_cnt  (run_cnt),
      .locked   (locked),
      .lock_out (lock_out)
   );

endmodule

// File: rtl/lock_filter_chk.sv
module lock_filter_chk #(
   parameter int CNT_W       = 8,
   parameter int TIGHT_TICKS = 6,
   parameter int LOOSE_TICKS = 12,
   parameter int GOOD_RUN    = 5,
   localparam int RUN_W      = $clog2(GOOD_RUN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_down,
   input logic             lock_out,
   input logic             eval_v,
   input logic [CNT_W-1:0] eval_w,
   input logic [RUN_W-1:0] run_cnt,
   input logic             locked
);

   localparam logic [CNT_W-1:0] TIGHT_V = CNT_W'(TIGHT_TICKS);
   localparam logic [CNT_W-1:0] LOOSE_V = CNT_W'(LOOSE_TICKS);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GOOD_RUN);
   localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(GOOD_RUN - 1);

   // R8: power-down forces the output high on the next edge
   a_r8_pd_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> lock_out);

   // R4: a wide window drops lock and empties the run
   a_r4_wide_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_v && eval_w > LOOSE_V && !pwr_down) |=> (!locked && run_cnt == '0));

   // R5: a middle window empties the run but keeps the lock state
   a_r5_mid_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_v && eval_w >= TIGHT_V && eval_w <= LOOSE_V && !pwr_down)
      |=> (locked == $past(locked) && run_cnt == '0));

   // R3: lock rises only on the evaluation that completes the run
   a_r3_lock_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(eval_v) && $past(run_cnt) == RUN_PRE));

   // R3: run counter bounded
   a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= RUN_MAX);

   // R2: without an evaluation the lock state cannot move
   a_r2_no_eval_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!eval_v && !pwr_down) |=> locked == $past(locked));

   // R9: leaving power-down starts from unlocked with an empty run
   a_r9_exit_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_down) |-> (!locked && run_cnt == '0));

endmodule

bind lock_filter lock_filter_chk #(
   .CNT_W       (CNT_W),
   .TIGHT_TICKS (TIGHT_TICKS),
   .LOOSE_TICKS (LOOSE_TICKS),
   .GOOD_RUN    (GOOD_RUN)
) u_chk (
   .clk      (clk_smp),
   .rst_n    (rst_n),
   .pwr_down (pwr_down),
   .lock_out (lock_out),
   .eval_v   (eval_v),
   .eval_w   (eval_w),
   .run_cnt  (run_cnt),
   .locked   (locked)
);

// File: tb/lock_filter_test.sv
module lock_filter_test;

   localparam int BCNT_W = 5;
   localparam int WMAX   = (1 << BCNT_W) - 1;
   localparam int TIGHT  = 6;
   localparam int LOOSE  = 12;
   localparam int RUN    = 5;
   localparam int WIN    = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_strobe = 1'b0;
   logic err_up = 1'b0;
   logic err_dn = 1'b0;
   logic pwr_down = 1'b0;
   logic lock_out;

   int    checks = 0;
   int    errors = 0;
   int    mrun = 0;
   logic  exp_lock = 1'b0;
   string tag_prev = "R1";

   always #2 clk = ~clk;

   lock_filter #(
      .CNT_W       (BCNT_W),
      .TIGHT_TICKS (TIGHT),
      .LOOSE_TICKS (LOOSE),
      .GOOD_RUN    (RUN),
      .SYNC_STAGES (2)
   ) uut (
      .clk_smp    (clk),
      .rst_n      (rst_n),
      .cmp_strobe (cmp_strobe),
      .err_up     (err_up),
      .err_dn     (err_dn),
      .pwr_down   (pwr_down),
      .lock_out   (lock_out)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s lock_out actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // window-level model of the hysteresis filter
   task automatic model_update(input int w, input bit pd, input string over);
      int eff;
      if (pd) begin
         mrun = 0;
         exp_lock = 1'b0;
         tag_prev = "R9";
         return;
      end
      eff = (w > WMAX) ? WMAX : w;
      if (eff < TIGHT) begin
         if (mrun < RUN) mrun++;
         if (mrun == RUN) exp_lock = 1'b1;
         tag_prev = (eff == 0) ? "R6" : "R3";
      end else if (eff > LOOSE) begin
         mrun = 0;
         exp_lock = 1'b0;
         tag_prev = (w > WMAX) ? "R10" : "R4";
      end else begin
         mrun = 0;
         tag_prev = "R5";
      end
      if (over != "") tag_prev = over;
   endtask

   // mode: 0 up only, 1 down only, 2 overlapping up and down (w >= 4)
   task automatic win(input int len, input int s, input int w, input int mode,
                      input bit pd, input string over);
      for (int t = 0; t < len; t++) begin
         logic on;
         @(negedge clk);
         if (t == 8) chk(lock_out, pd ? 1'b1 : exp_lock, pd ? "R8" : tag_prev);
         on = (t >= s) && (t < s + w);
         cmp_strobe = (t == 0);
         pwr_down   = pd;
         case (mode)
            0: begin err_up = on; err_dn = 1'b0; end
            1: begin err_up = 1'b0; err_dn = on; end
            default: begin
               err_up = (t >= s) && (t < s + w - 3);
               err_dn = (t >= s + 2) && (t < s + w);
            end
         endcase
      end
      model_update(w, pd, over);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(lock_out, 1'b0, "R1");

      // R3: boundary-good width 5 builds the run
      for (int i = 0; i < 6; i++) win(WIN, 10, 5, i % 2, 1'b0, "");
      // R5: edges of the middle band keep lock
      win(WIN, 10, 6, 0, 1'b0, "");
      win(WIN, 12, 12, 1, 1'b0, "");
      // R4: first wide width drops lock
      win(WIN, 10, 13, 0, 1'b0, "");
      // R6: empty windows lock
      for (int i = 0; i < 6; i++) win(WIN, 10, 0, 0, 1'b0, "");
      // R7: wide pulse ending on the strobe tick
      win(WIN, WIN - 20, 20, 0, 1'b0, "R7");
      // R7: tight pulses ending on the strobe tick, counted once each
      for (int i = 0; i < 6; i++) win(WIN, WIN - 4, 4, 1, 1'b0, "R7");
      // R2: overlapping up and down pulses form one wide error
      win(WIN, 10, 20, 2, 1'b0, "R2");
      for (int i = 0; i < 5; i++) win(WIN, 11, 5, 2, 1'b0, "R2");
      // R10: overlong pulse saturates and still counts as wide
      win(WIN, 10, 3, 0, 1'b0, "");
      win(64, 10, 40, 0, 1'b0, "");
      // R8 / R9: power-down then relock
      for (int i = 0; i < 5; i++) win(WIN, 10, 2, 0, 1'b0, "");
      win(WIN, 10, 0, 0, 1'b1, "");
      win(WIN, 10, 0, 0, 1'b1, "");
      for (int i = 0; i < 6; i++) win(WIN, 10, 1, 0, 1'b0, "");

      // constrained random windows
      for (int i = 0; i < 250; i++) begin
         int sel;
         int w;
         int s;
         int mode;
         sel  = int'($urandom % 10);
         s    = 10 + int'($urandom % 5);
         if (sel < 6 || sel == 9) w = int'($urandom % 6);
         else if (sel < 8)        w = 6 + int'($urandom % 7);
         else                     w = 13 + int'($urandom % 16);
         mode = int'($urandom % 3);
         if (mode == 2 && w < 4) mode = 0;
         if ($urandom % 40 == 0) begin
            win(WIN, 10, 0, 0, 1'b1, "");
            win(WIN, 10, 0, 0, 1'b1, "");
         end
         win(WIN, s, w, mode, 1'b0, "");
      end
      win(WIN, 10, 0, 0, 1'b0, "");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule